// File: doc/BRIEF.md
# Condition-Field Masked Logic Unit

This unit executes a small family of instructions that operate on 4-bit condition fields. It owns an eight-entry file of these fields. Each cycle it may accept one 32-bit instruction word together with the value of one integer register. Under a 4-bit mask, it compares each bit of a source field, or the low bit of the integer operand, against a per-bit expected value.

The per-bit results are then used in one of three ways. They can be reduced by AND or OR to one bit, which goes to an integer register or to a single condition bit. They can be merged into a destination field. In the masked move, they can be inverted bit by bit with XOR. A merge flag in the instruction selects between two behaviours for field writes. With the flag set, the write is a read-modify-write. With it clear, the write overwrites the field.

The integer result leaves the unit through a registered write port. The whole field file is visible on a flat output bus.

Top module: `cfield_logic_unit`

## Requirements
- R1: An instruction is accepted only when in_valid is high and the primary opcode in in_instr[31:26] equals 19. Any other cycle leaves every field unchanged and raises no integer write. The operation selector is in_instr[12:11].
- R2: For each field position i, hit_i = mask[i] AND (expect[i] == tested_i). The mask is in_instr[19:16], expect is in_instr[4:1] and the merge flag M is in_instr[20]. Bit 3 of each 4-bit value pairs with bit 3 of the field, which is the field's most significant bit.
- R3: Selector 00 tests the field named by in_instr[15:13]. The hits are reduced with OR when M=1 and with AND when M=0. One cycle after acceptance, int_wr_en is high for one cycle, int_wr_idx equals in_instr[25:21], and int_wr_data holds the reduced bit in bit 0 with all other bits zero.
- R4: Under selector 00 with in_instr[0] set, field 0 is written from the integer result at the same edge. The field reads 4'b1000 if the result is negative, 4'b0100 if it is positive, and 4'b0010 if it is zero.
- R5: Selector 01 uses int_opnd[0] as the tested bit at all four positions. If the register index in_instr[25:21] is 0, the tested bit is 0 whatever int_opnd holds. The hit vector is written to the field named by in_instr[15:13].
- R6: Selector 11 with in_instr[0]=0 tests the field named by in_instr[15:13]. It writes the hit vector to the field named by in_instr[25:23].
- R7: For selectors 01 and 11, M=1 keeps the destination's bits where the mask is 0. M=0 clears those bits.
- R8: Selector 11 with in_instr[0]=1 writes ((mask AND source) OR (M ? destination AND NOT mask : 0)) XOR expect to the destination field.
- R9: Selector 10 reduces the hits as in R3 and writes the result into one condition bit. in_instr[25:23] names the field and b = in_instr[22:21] names the bit, with b=0 being the field's bit 3. Every other bit of the file is unchanged.
- R10: Only field operations write fields, apart from the field 0 update of R4. Field operations never raise int_wr_en.
- R11: Reset (rst_n low) clears all eight fields and int_wr_en.
- R12: A field write is visible on cf_all from the clock edge that accepts the instruction. An instruction accepted at the next edge reads the updated value.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_instr | input | 32 | Instruction word |
| int_opnd | input | XLEN | Value of the integer register named in the instruction |
| int_wr_en | output | 1 | Integer result write strobe |
| int_wr_idx | output | 5 | Integer destination register index |
| int_wr_data | output | XLEN | Integer result |
| cf_all | output | 32 | Field file, field k at bits 4k+3..4k |

## Verification
A wrong internal field value cannot stay hidden. cf_all exposes the whole file, so a corrupted field shows on the next sample after the edge that wrote it. A wrong value that no write exposes still shows one cycle later, when an instruction reads it as source or merge destination. A decode fault shows differently: one operation may be steered onto another's datapath, or the wrong field may be targeted. In that case the wrong field changes, or an unexpected integer strobe appears, one cycle after acceptance. Random words that reuse fields heavily tie each such fault to a port difference within a few instructions.

// File: rtl/cfl_pkg.sv
package cfl_pkg;

    localparam int FW       = 4;
    localparam int FIDX_W   = 3;
    localparam int NFIELD   = 1 << FIDX_W;
    localparam int RIDX_W   = 5;
    localparam int BSEL_W   = $clog2(FW);
    localparam int IW       = 32;
    localparam logic [5:0] PRIMARY_OP = 6'd19;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_TO_INT,
        OP_FROM_INT,
        OP_SET_BIT,
        OP_FLD_CMP,
        OP_FLD_MOVE
    } cfl_op_e;

    typedef struct packed {
        cfl_op_e             op;
        logic                merge;
        logic [FW-1:0]       mask;
        logic [FW-1:0]       expect_v;
        logic [FIDX_W-1:0]   src_fld;
        logic [FIDX_W-1:0]   dst_fld;
        logic [RIDX_W-1:0]   reg_idx;
        logic [BSEL_W-1:0]   bit_sel;
        logic                rc;
    } cfl_dec_t;

endpackage

// File: rtl/cfl_decode.sv
module cfl_decode
    import cfl_pkg::*;
(
    input  logic          valid,
    input  logic [IW-1:0] instr,
    output cfl_dec_t      dec
);

    always_comb begin
        dec          = '0;
        dec.op       = OP_NONE;
        dec.merge    = instr[20];
        dec.mask     = instr[19:16];
        dec.expect_v = instr[4:1];
        dec.src_fld  = instr[15:13];
        dec.reg_idx  = instr[25:21];
        dec.bit_sel  = instr[22:21];
        dec.dst_fld  = instr[25:23];
        if (valid && instr[31:26] == PRIMARY_OP) begin
            unique case (instr[12:11])
                2'b00: dec.op = OP_TO_INT;
                2'b01: dec.op = OP_FROM_INT;
                2'b10: dec.op = OP_SET_BIT;
                default: dec.op = instr[0] ? OP_FLD_MOVE : OP_FLD_CMP;
            endcase
        end
        if (dec.op == OP_FROM_INT) begin
            dec.dst_fld = instr[15:13];
        end
        dec.rc = instr[0] && (dec.op == OP_TO_INT);
    end

endmodule

// File: rtl/cfl_bit_test.sv
module cfl_bit_test (
    input  logic mask_b,
    input  logic expect_b,
    input  logic tested_b,
    output logic hit
);

    always_comb begin
        hit = mask_b & ~(expect_b ^ tested_b);
    end

endmodule

// File: rtl/cfl_eval.sv
module cfl_eval
    import cfl_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  cfl_dec_t          dec,
    input  logic [FW-1:0]     src_val,
    input  logic [FW-1:0]     dst_val,
    input  logic              int_lsb,
    output logic              fld_we,
    output logic [FIDX_W-1:0] fld_idx,
    output logic [FW-1:0]     fld_val,
    output logic              int_we,
    output logic [XLEN-1:0]   int_val,
    output logic              cr0_we,
    output logic [FW-1:0]     cr0_val
);

    logic [FW-1:0] tested;
    logic [FW-1:0] hits;
    logic          reduced;
    logic [FW-1:0] keep;

    always_comb begin
        tested = (dec.op == OP_FROM_INT) ? {FW{int_lsb}} : src_val;
    end

    for (genvar i = 0; i < FW; i++) begin : g_bit
        cfl_bit_test u_bit (
            .mask_b   (dec.mask[i]),
            .expect_b (dec.expect_v[i]),
            .tested_b (tested[i]),
            .hit      (hits[i])
        );
    end

    always_comb begin
        reduced = dec.merge ? (|hits) : (&hits);
        keep    = dec.merge ? (dst_val & ~dec.mask) : '0;
        fld_we  = 1'b0;
        fld_idx = dec.dst_fld;
        fld_val = dst_val;
        int_we  = 1'b0;
        int_val = '0;
        cr0_we  = 1'b0;
        cr0_val = '0;
        unique case (dec.op)
            OP_TO_INT: begin
                int_we     = 1'b1;
                int_val[0] = reduced;
                cr0_we     = dec.rc;
            end
            OP_FROM_INT, OP_FLD_CMP: begin
                fld_we  = 1'b1;
                fld_val = hits | keep;
            end
            OP_FLD_MOVE: begin
                fld_we  = 1'b1;
                fld_val = ((dec.mask & src_val) | keep) ^ dec.expect_v;
            end
            OP_SET_BIT: begin
                fld_we  = 1'b1;
                fld_val = dst_val;
                fld_val[FW-1-int'(dec.bit_sel)] = reduced;
            end
            default: ;
        endcase
        // signed analysis of the integer result: {neg, pos, zero, 0}
        cr0_val[FW-1] = int_val[XLEN-1];
        cr0_val[FW-2] = !int_val[XLEN-1] && (int_val != '0);
        cr0_val[FW-3] = (int_val == '0);
    end

endmodule

// File: rtl/cfield_logic_unit.sv
module cfield_logic_unit
    import cfl_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [IW-1:0]        in_instr,
    input  logic [XLEN-1:0]      int_opnd,
    output logic                 int_wr_en,
    output logic [RIDX_W-1:0]    int_wr_idx,
    output logic [XLEN-1:0]      int_wr_data,
    output logic [NFIELD*FW-1:0] cf_all
);

    typedef struct packed {
        logic [NFIELD-1:0][FW-1:0] fld;
        logic                      int_we;
        logic [RIDX_W-1:0]         int_idx;
        logic [XLEN-1:0]           int_data;
    } state_t;

    state_t st_d, st_q;

    cfl_dec_t          dec;
    logic              int_lsb;
    logic              fld_we, int_we, cr0_we;
    logic [FIDX_W-1:0] fld_idx;
    logic [FW-1:0]     fld_val, cr0_val;
    logic [XLEN-1:0]   int_val;

    cfl_decode u_dec (
        .valid (in_valid),
        .instr (in_instr),
        .dec   (dec)
    );

    always_comb begin
        int_lsb = (dec.reg_idx == '0) ? 1'b0 : int_opnd[0];
    end

    cfl_eval #(.XLEN(XLEN)) u_eval (
        .dec     (dec),
        .src_val (st_q.fld[dec.src_fld]),
        .dst_val (st_q.fld[dec.dst_fld]),
        .int_lsb (int_lsb),
        .fld_we  (fld_we),
        .fld_idx (fld_idx),
        .fld_val (fld_val),
        .int_we  (int_we),
        .int_val (int_val),
        .cr0_we  (cr0_we),
        .cr0_val (cr0_val)
    );

    always_comb begin
        st_d        = st_q;
        st_d.int_we = 1'b0;
        if (fld_we) begin
            st_d.fld[fld_idx] = fld_val;
        end
        if (cr0_we) begin
            st_d.fld[0] = cr0_val;
        end
        if (int_we) begin
            st_d.int_we   = 1'b1;
            st_d.int_idx  = dec.reg_idx;
            st_d.int_data = int_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_wr_en   = st_q.int_we;
    assign int_wr_idx  = st_q.int_idx;
    assign int_wr_data = st_q.int_data;
    assign cf_all      = st_q.fld;

    p_reset_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cf_all == '0 && !int_wr_en));

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.op == OP_NONE) |=> ($stable(cf_all) && !int_wr_en));

    p_int_lsb_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int_wr_en |-> (int_wr_data[XLEN-1:1] == '0));

    p_int_keeps_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.op == OP_TO_INT) |=> (cf_all[NFIELD*FW-1:FW] == $past(cf_all[NFIELD*FW-1:FW])));

    p_field_op_no_int_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.op inside {OP_FROM_INT, OP_SET_BIT, OP_FLD_CMP, OP_FLD_MOVE}) |=> !int_wr_en);

    p_single_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.op == OP_SET_BIT) |=> ($countones(cf_all ^ $past(cf_all)) <= 1));

    p_overwrite_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec.op inside {OP_FROM_INT, OP_FLD_CMP}) && !dec.merge)
        |=> ((st_q.fld[$past(dec.dst_fld)] & ~$past(dec.mask)) == '0));

endmodule

// File: tb/test_cfield_logic_unit.sv
module test_cfield_logic_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [63:0] int_opnd = '0;
    logic        int_wr_en;
    logic [4:0]  int_wr_idx;
    logic [63:0] int_wr_data;
    logic [31:0] cf_all;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [3:0]  m_fld [8];
    logic        exp_we;
    logic [4:0]  exp_idx;
    logic [63:0] exp_data;
    string       exp_tag;

    always #4 clk = ~clk;

    cfield_logic_unit i_cfield_logic_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_instr    (in_instr),
        .int_opnd    (int_opnd),
        .int_wr_en   (int_wr_en),
        .int_wr_idx  (int_wr_idx),
        .int_wr_data (int_wr_data),
        .cf_all      (cf_all)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] sel, input logic [4:0] hi5,
                                       input logic m, input logic [3:0] mask,
                                       input logic [2:0] src, input logic [3:0] md,
                                       input logic b0);
        return {6'd19, hi5, m, mask, src, sel, 6'b0, md, b0};
    endfunction

    function automatic logic [31:0] model_flat();
        logic [31:0] f;
        for (int k = 0; k < 8; k++) f[4*k +: 4] = m_fld[k];
        return f;
    endfunction

    task automatic model_step(input logic v, input logic [31:0] ins, input logic [63:0] op);
        logic [3:0] mask, md, src, n, keep, dst;
        logic       m, tb, red;
        logic [2:0] d;
        logic [1:0] b;
        exp_we = 1'b0;
        exp_tag = "R1";
        if (!v || ins[31:26] != 6'd19) return;
        mask = ins[19:16];
        md   = ins[4:1];
        m    = ins[20];
        src  = m_fld[ins[15:13]];
        n    = mask & ~(md ^ src);
        red  = m ? |n : &n;
        case (ins[12:11])
            2'b00: begin
                exp_we   = 1'b1;
                exp_idx  = ins[25:21];
                exp_data = {63'b0, red};
                exp_tag  = "R3 R2";
                if (ins[0]) begin
                    m_fld[0] = red ? 4'b0100 : 4'b0010;
                    exp_tag = "R4";
                end
            end
            2'b01: begin
                tb   = (ins[25:21] == 5'd0) ? 1'b0 : op[0];
                n    = mask & ~(md ^ {4{tb}});
                d    = ins[15:13];
                keep = m ? (m_fld[d] & ~mask) : 4'b0;
                m_fld[d] = n | keep;
                exp_tag = "R5 R7";
            end
            2'b10: begin
                d = ins[25:23];
                b = ins[22:21];
                m_fld[d][3 - b] = red;
                exp_tag = "R9";
            end
            default: begin
                d    = ins[25:23];
                dst  = m_fld[d];
                keep = m ? (dst & ~mask) : 4'b0;
                if (ins[0]) begin
                    m_fld[d] = ((mask & src) | keep) ^ md;
                    exp_tag = "R8 R12";
                end else begin
                    m_fld[d] = n | keep;
                    exp_tag = "R6 R7";
                end
            end
        endcase
    endtask

    task automatic step(input logic v, input logic [31:0] ins, input logic [63:0] op);
        @(negedge clk);
        in_valid = v;
        in_instr = ins;
        int_opnd = op;
        model_step(v, ins, op);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check({exp_tag, " fields"}, {32'b0, cf_all}, {32'b0, model_flat()});
        check({exp_tag, " R10 int_wr_en"}, {63'b0, int_wr_en}, {63'b0, exp_we});
        if (exp_we) begin
            check({exp_tag, " int_wr_idx"}, {59'b0, int_wr_idx}, {59'b0, exp_idx});
            check({exp_tag, " int_wr_data"}, int_wr_data, exp_data);
        end
    endtask

    initial begin
        #1600000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int k = 0; k < 8; k++) m_fld[k] = 4'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11 fields after reset", {32'b0, cf_all}, 64'd0);
        check("R11 int_wr_en after reset", {63'b0, int_wr_en}, 64'd0);

        // R5: register index 0 reads as zero although int_opnd is 1 -> 1111
        step(1'b1, mk(2'b01, 5'd0, 1'b0, 4'b1111, 3'd3, 4'b0000, 1'b0), 64'd1);
        // R7 merge: 0011 & ~(0001^1111) = 0001, kept 1100 -> 1101
        step(1'b1, mk(2'b01, 5'd7, 1'b1, 4'b0011, 3'd3, 4'b0001, 1'b0), 64'd1);
        // R8 R12: move field 3 (1101) to field 5 inverted -> 0010
        step(1'b1, mk(2'b11, {3'd5, 2'b00}, 1'b0, 4'b1111, 3'd3, 4'b1111, 1'b1), 64'd0);
        // R9: OR reduction of field 3 into field 6 bit 0 (its MSB) -> 1000
        step(1'b1, mk(2'b10, {3'd6, 2'b00}, 1'b1, 4'b1000, 3'd3, 4'b1000, 1'b0), 64'd0);
        // R3: AND reduction with a masked-out bit gives 0; R4 sets field 0 to 0010
        step(1'b1, mk(2'b00, 5'd9, 1'b0, 4'b1000, 3'd6, 4'b1000, 1'b1), 64'd0);
        // R4: OR reduction gives 1 -> field 0 becomes 0100
        step(1'b1, mk(2'b00, 5'd9, 1'b1, 4'b1000, 3'd6, 4'b1000, 1'b1), 64'd0);
        // R6: compare field 3 into field 2, overwrite
        step(1'b1, mk(2'b11, {3'd2, 2'b00}, 1'b0, 4'b0110, 3'd3, 4'b0100, 1'b0), 64'd0);
        // R1: wrong primary opcode and deasserted valid have no effect
        step(1'b1, {6'd18, mk(2'b01, 5'd0, 1'b0, 4'b1111, 3'd4, 4'b0000, 1'b0)}[31:0] ^ 32'h0400_0000 | 32'h0, 64'd0);
        step(1'b0, mk(2'b01, 5'd0, 1'b0, 4'b1111, 3'd4, 4'b0000, 1'b0), 64'd0);

        for (int s = 0; s < 800; s++) begin
            logic [31:0] ins;
            logic v;
            ins = $urandom;
            if (($urandom % 16) != 0) ins[31:26] = 6'd19;
            v = (($urandom % 8) != 0);
            step(v, ins, {$urandom, $urandom});
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule